// File: doc/BRIEF.md
# Strided 2D Tile Address Generator

This block sequences read addresses for a byte image held row-major in a memory outside the block. It cuts the image into square tiles that overlap, because the tile origin moves by less than the tile width. For each tile it streams the linear address of every pixel of that tile in raster order. The default geometry is an image 580 pixels wide and 196 tall, 8x8 tiles, and a step of 4 along both axes. That gives a grid of 144 tile positions across and 48 down.

A one-cycle start pulse launches a full traversal. The tile origin moves across one row of tile positions before it drops to the next row of tiles, and inside each tile the pixels come out column by column along a row before the next row. Each address carries a flag for the first pixel of a tile and a flag for the last pixel of a tile. The consumer takes addresses with a ready/valid handshake. After the final address of the final tile has been taken, a one-cycle done pulse appears and the generator goes back to idle. All geometry figures are parameters.

Top module: `strided_tile_addrgen`

## Requirements
- R1: While reset is held and right after reset, valid_o and done_o are low.
- R2: In the cycle after a start pulse is seen while idle, valid_o is high, addr_o is 0 and tile_first_o is high.
- R3: Inside a tile, the address of pixel (r, c) is origin + r*COLS + c. Here c runs 0..TILE-1 fastest and r runs 0..TILE-1.
- R4: The tile origin advances STRIDE columns at a time through NX positions. It then moves down STRIDE rows and starts again at column 0, for NY rows of tiles. One traversal therefore yields NX*NY*TILE*TILE addresses.
- R5: tile_first_o is high exactly on the first address of each tile, and tile_last_o is high exactly on the TILE*TILE-th address.
- R6: While valid_o is high and ready_i is low, valid_o, addr_o and both flags hold their values into the next cycle. The sequence advances only on a handshake.
- R7: After the handshake on the last address of the last tile, done_o is high for exactly one cycle with valid_o low. The block is then idle and accepts a new start pulse, including one given during the done cycle.
- R8: A start pulse that arrives during a traversal has no effect on the address sequence.
- R9: Every address is below COLS*ROWS, and the last address of a traversal is COLS*ROWS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a traversal when idle |
| ready_i | input | 1 | Consumer accepts the current address |
| valid_o | output | 1 | addr_o and its flags are valid |
| addr_o | output | $clog2(COLS*ROWS) | Linear pixel address |
| tile_first_o | output | 1 | First address of a tile |
| tile_last_o | output | 1 | Last address of a tile |
| done_o | output | 1 | One-cycle pulse after the final address |

## Verification
The hardest states to reach are the carry points where several counters wrap on the same handshake. Examples are the last pixel of the last tile in a row of tiles and the final pixel of the traversal, and these matter most when the consumer stalls exactly there or when a start pulse lands there. The bench uses a reduced geometry with the same shape (20x16 image, 8x8 tiles, step 4) so that complete traversals fit in a short run. It drives complete traversals with ready held high, then with ready pseudo-randomly dropped and stray start pulses, and then a restart issued in the done cycle itself. Every cycle is compared against an index-based reference that derives each address by division rather than by counting.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
  // Linear address of pixel (r, c) of the tile whose grid position is (tx, ty).
  function automatic int unsigned pixel_addr(input int unsigned tx, input int unsigned ty,
                                             input int unsigned r, input int unsigned c,
                                             input int unsigned cols, input int unsigned stride);
    return (ty * stride + r) * cols + tx * stride + c;
  endfunction

  // Counter width that can hold 0..limit-1.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/tile_axis_counter.sv
module tile_axis_counter #(
  parameter int unsigned LIMIT = 8,
  localparam int unsigned CW = tgen_pkg::cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_max
);
  assign at_max = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (inc)    cnt <= at_max ? '0 : cnt + 1'b1;
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/strided_tile_addrgen.sv
module strided_tile_addrgen #(
  parameter int unsigned COLS   = 580,
  parameter int unsigned ROWS   = 196,
  parameter int unsigned TILE   = 8,
  parameter int unsigned STRIDE = 4,
  parameter int unsigned NX     = 144,
  parameter int unsigned NY     = 48,
  localparam int unsigned ADDR_W = $clog2(COLS * ROWS),
  localparam int unsigned TW     = tgen_pkg::cnt_width(TILE),
  localparam int unsigned XW     = tgen_pkg::cnt_width(NX),
  localparam int unsigned YW     = tgen_pkg::cnt_width(NY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tile_first_o,
  output logic              tile_last_o,
  output logic              done_o
);
  logic busy_q, done_q;

  // Named events used by the counters and the assertions
  logic hs, start_go, col_wrap_ev, tile_done_ev, gridrow_done_ev, final_ev;
  logic [TW-1:0] col_cnt, row_cnt;
  logic [XW-1:0] tx_cnt;
  logic [YW-1:0] ty_cnt;
  logic col_max, row_max, tx_max, ty_max;

  assign hs              = busy_q & ready_i;
  assign start_go        = ~busy_q & start_i;
  assign col_wrap_ev     = hs & col_max;
  assign tile_done_ev    = col_wrap_ev & row_max;
  assign gridrow_done_ev = tile_done_ev & tx_max;
  assign final_ev        = gridrow_done_ev & ty_max;

  tile_axis_counter #(.LIMIT(TILE)) u_col (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .inc(hs),
    .cnt(col_cnt), .at_max(col_max));
  tile_axis_counter #(.LIMIT(TILE)) u_row (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .inc(col_wrap_ev),
    .cnt(row_cnt), .at_max(row_max));
  tile_axis_counter #(.LIMIT(NX)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .inc(tile_done_ev),
    .cnt(tx_cnt), .at_max(tx_max));
  tile_axis_counter #(.LIMIT(NY)) u_ty (
    .clk(clk), .rst_n(rst_n), .clr(start_go), .inc(gridrow_done_ev),
    .cnt(ty_cnt), .at_max(ty_max));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= final_ev;
      if (start_go)      busy_q <= 1'b1;
      else if (final_ev) busy_q <= 1'b0;
    end
  end

  assign valid_o      = busy_q;
  assign done_o       = done_q;
  assign tile_first_o = busy_q & (col_cnt == '0) & (row_cnt == '0);
  assign tile_last_o  = busy_q & col_max & row_max;
  assign addr_o = ADDR_W'(tgen_pkg::pixel_addr(32'(tx_cnt), 32'(ty_cnt), 32'(row_cnt),
                                               32'(col_cnt), COLS, STRIDE));

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(tile_first_o)
                               && $stable(tile_last_o)));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!valid_o && $past(hs && tile_last_o)));
  // R5
  next_tile_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && tile_last_o && !final_ev) |=> tile_first_o);
  // R2
  start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (valid_o && tile_first_o && addr_o == '0));
  // R9
  addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (32'(addr_o) < COLS * ROWS));
endmodule

// File: tb/strided_tile_addrgen_tb.sv
module strided_tile_addrgen_tb;
  localparam int COLS = 20, ROWS = 16, T = 8, S = 4, NX = 4, NY = 3;
  localparam int TOTAL = NX * NY * T * T;
  localparam int AW = $clog2(COLS * ROWS);

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, ready_i = 1'b0;
  logic valid_o, tile_first_o, tile_last_o, done_o;
  logic [AW-1:0] addr_o;

  always #2.5 clk = ~clk;

  strided_tile_addrgen #(.COLS(COLS), .ROWS(ROWS), .TILE(T), .STRIDE(S), .NX(NX), .NY(NY)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(ready_i), .valid_o(valid_o),
    .addr_o(addr_o), .tile_first_o(tile_first_o), .tile_last_o(tile_last_o), .done_o(done_o));

  int checks = 0, errors = 0;
  int m_k = 0, max_seen = -1, seen_total = 0;
  bit m_busy = 0, m_done = 0, just_started = 0;
  bit prev_stall = 0;
  int prev_addr = 0;

  function automatic int exp_addr(input int k);
    int t = k / (T * T), p = k % (T * T);
    return ((t / NX) * S + p / T) * COLS + (t % NX) * S + (p % T);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit rdy, input bit st);
    bit nd;
    @(negedge clk);
    chk(valid_o == m_busy, "R7 valid", int'(valid_o), int'(m_busy));
    chk(done_o == m_done, "R7 done", int'(done_o), int'(m_done));
    if (m_busy && valid_o) begin
      chk(int'(addr_o) == exp_addr(m_k), "R3/R4 addr", int'(addr_o), exp_addr(m_k));
      chk(tile_first_o == (m_k % (T*T) == 0), "R5 first", int'(tile_first_o), int'(m_k % (T*T) == 0));
      chk(tile_last_o == (m_k % (T*T) == T*T-1), "R5 last", int'(tile_last_o), int'(m_k % (T*T) == T*T-1));
      chk(int'(addr_o) < COLS * ROWS, "R9 bound", int'(addr_o), COLS * ROWS - 1);
      if (int'(addr_o) > max_seen) max_seen = int'(addr_o);
      if (just_started)
        chk(addr_o == '0 && tile_first_o, "R2 start", int'(addr_o), 0);
      if (prev_stall)
        chk(int'(addr_o) == prev_addr, "R6 hold", int'(addr_o), prev_addr);
    end
    just_started = 0;
    prev_stall = valid_o && !rdy;
    prev_addr = int'(addr_o);
    ready_i = rdy;
    start_i = st;
    nd = m_busy && rdy && (m_k == TOTAL - 1);
    if (m_busy) begin
      if (rdy) begin
        seen_total++;
        if (m_k == TOTAL - 1) begin m_busy = 0; m_k = 0; end
        else m_k++;
      end
    end else if (st) begin
      m_busy = 1; m_k = 0; just_started = 1; seen_total = 0;
    end
    m_done = nd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!valid_o && !done_o, "R1 reset", int'(valid_o), 0);
    rst_n = 1'b1;
    step(0, 0);
    step(0, 0);
    // Phase 1: full traversal, ready always high (R3, R4, R5)
    step(1, 1);
    for (int i = 0; i < 2 * TOTAL && (m_busy || m_done); i++) step(1, 0);
    chk(seen_total == TOTAL, "R4 count", seen_total, TOTAL);
    chk(max_seen == COLS * ROWS - 1, "R9 max", max_seen, COLS * ROWS - 1);
    step(1, 0);
    // Phase 2: random stalls (R6) and stray starts while busy (R8)
    step(0, 1);
    for (int i = 0; i < 6 * TOTAL && m_busy; i++)
      step(($urandom % 3) != 0, (i % 37) == 5);
    chk(seen_total == TOTAL, "R8 count", seen_total, TOTAL);
    // Phase 3: restart in the done cycle (R7), periodic stalls
    step(1, 1);
    for (int i = 0; i < 3 * TOTAL && m_busy; i++) step((i % 5) != 2, 0);
    step(1, 0);
    step(1, 0);
    chk(seen_total == TOTAL, "R7 restart count", seen_total, TOTAL);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule